// File: doc/BRIEF.md
# Byte-Wide Double-Buffered Dual Converter Loader

This block sits between an 8-bit host bus and a pair of 12-bit converter channels. Each channel keeps a staging pair: an 8-bit low register and a 4-bit high register. The host fills these one at a time. A two-bit address selects the channel and the byte within it. Chip select and write strobe, both active low, qualify each write.

An active-low update control moves the staged words into both output registers in the same cycle, so the two channels change together. When update, chip select and write are all asserted at once, the block is transparent: the byte being written passes into the staging register and into the output register in the same cycle.

An asynchronous active-low clear and a synchronous active-low reset each empty every register. The storage elements are clocked registers that load on each clock edge at which their enable condition holds.

Top module: `dual_byte_loader`

## Requirements
- R1: With `sel_n`=0, `wr_n`=0 and `upd_n`=1, address 0 stores `din[7:0]` as channel A bits 7:0, and address 1 stores `din[3:0]` as channel A bits 11:8. Address bit 1 selects the channel (0 = A, 1 = B), and address bit 0 selects the lane (0 = low byte, 1 = high nibble).
- R2: Address 2 stores `din[7:0]` as channel B bits 7:0, and address 3 stores `din[3:0]` as channel B bits 11:8. Writes to one channel never alter the other channel's staged word.
- R3: While `upd_n`=1, neither output changes at any clock edge, whatever is written to the staging registers.
- R4: At a clock edge with `upd_n`=0, `wr_n`=0 and `sel_n`=1, both outputs take their channel's staged word, and the new values are visible after that edge.
- R5: At a clock edge with `upd_n`, `sel_n` and `wr_n` all 0, the addressed byte is written to staging, and both outputs take the staged words with that byte already merged in, after the same edge.
- R6: At a clock edge with `wr_n`=1, nothing is stored: neither the staging registers nor the outputs change, whatever `upd_n`, `sel_n`, `addr` and `din` are.
- R7: While `clr_n`=0, both outputs read 0 without waiting for a clock edge, and all staged words are 0. A later update then yields 0 on both outputs.
- R8: A high-lane write ignores `din[7:4]`. Nibble bit 3 lands on output bit 11 and bit 0 lands on bit 8, so bytes 0xBC then 0xFA give 0xABC.
- R9: At a clock edge with `rst_n`=0, every staging and output register becomes 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clr_n | input | 1 | Asynchronous clear, active low |
| sel_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| upd_n | input | 1 | Shared update, active low |
| addr | input | 2 | Bit 1 selects the channel, bit 0 selects the lane |
| din | input | 8 | Host data byte |
| out_a | output | 12 | Channel A output register |
| out_b | output | 12 | Channel B output register |

## Verification
The bench aims at the merge in transparent mode. A design that committed the old staged word there would lag by one write, and a design that skipped the staging register would lose that byte at the next plain update.

It also covers update with the strobe idle. A design that ignored `wr_n` during update would move the outputs anyway.

Further cases are high-lane writes with noisy upper bits, which catch a design that maps the wrong nibble, and writes to one channel followed by an update, which catch cross-channel leakage. Clear is applied between edges, so a design that cleared only on the clock would show stale outputs.

// File: rtl/dbl_pkg.sv
// Package dbl_pkg
// Shared sizes and lane encoding for the dual byte loader.
// Assumes exactly two channels, matching the two output ports.
package dbl_pkg;
    localparam int BUS_W   = 8;
    localparam int NIB_W   = 4;
    localparam int WORD_W  = BUS_W + NIB_W;
    localparam int CH_CNT  = 2;
    localparam int CH_AW   = $clog2(CH_CNT);
    localparam int ADDR_W  = CH_AW + 1;

    typedef enum logic {
        LANE_LO = 1'b0,
        LANE_HI = 1'b1
    } lane_e;
endpackage

// File: rtl/dbl_addr_decode.sv
// Module dbl_addr_decode
// Turns chip select, write strobe and address into one write enable per
// channel and lane. Address LSB is the lane; the upper bits are the channel.
// Assumes active-low strobes that are already synchronous to clk.
module dbl_addr_decode #(
    parameter int CH_CNT = 2,
    parameter int CH_AW  = 1,
    parameter int ADDR_W = CH_AW + 1
) (
    input  logic              sel_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    output logic [CH_CNT-1:0] wr_lo,
    output logic [CH_CNT-1:0] wr_hi
);
    import dbl_pkg::*;

    logic bus_write;
    lane_e lane;

    assign bus_write = ~sel_n & ~wr_n;
    assign lane      = lane_e'(addr[0]);

    for (genvar c = 0; c < CH_CNT; c++) begin : g_dec
        // Enable of channel c, per lane.
        always_comb begin
            wr_lo[c] = bus_write && (addr[ADDR_W-1:1] == CH_AW'(c)) && (lane == LANE_LO);
            wr_hi[c] = bus_write && (addr[ADDR_W-1:1] == CH_AW'(c)) && (lane == LANE_HI);
        end
    end
endmodule

// File: rtl/dbl_input_bank.sv
// Module dbl_input_bank
// Staging registers of one channel: a low byte and a high nibble.
// Also gives the value the staging word takes at the coming edge, which
// lets a transparent update commit the byte being written.
// Assumes at most one of wr_lo / wr_hi is set in a cycle.
module dbl_input_bank #(
    parameter int BUS_W  = 8,
    parameter int NIB_W  = 4,
    parameter int WORD_W = BUS_W + NIB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_n,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BUS_W-1:0]  din,
    output logic [WORD_W-1:0] word,
    output logic [WORD_W-1:0] word_next
);
    logic [BUS_W-1:0] lo_q;
    logic [NIB_W-1:0] hi_q;
    logic [BUS_W-1:0] lo_d;
    logic [NIB_W-1:0] hi_d;

    // Next staging value, with the current bus write merged in.
    always_comb begin
        lo_d = wr_lo ? din : lo_q;
        hi_d = wr_hi ? din[NIB_W-1:0] : hi_q;
    end

    // Staging storage with async clear and sync reset.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            lo_q <= lo_d;
            hi_q <= hi_d;
        end
    end

    assign word      = {hi_q, lo_q};
    assign word_next = {hi_d, lo_d};

    // R8
    hi_map_chk: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        (rst_n && wr_hi) |=> word[WORD_W-1:BUS_W] == $past(din[NIB_W-1:0]));

    // R1
    lo_map_chk: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        (rst_n && wr_lo) |=> word[BUS_W-1:0] == $past(din));

    // R6
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        (rst_n && !wr_lo && !wr_hi) |=> $stable(word));
endmodule

// File: rtl/dbl_commit_reg.sv
// Module dbl_commit_reg
// Output register of one channel. Takes the supplied word on each edge at
// which load is high, and otherwise holds.
// Assumes load is already qualified by the update and write strobes.
module dbl_commit_reg #(
    parameter int WORD_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_n,
    input  logic              load,
    input  logic [WORD_W-1:0] d,
    output logic [WORD_W-1:0] q
);
    // Output storage with async clear and sync reset.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)
            q <= '0;
        else if (!rst_n)
            q <= '0;
        else if (load)
            q <= d;
    end

    // R4
    commit_chk: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        (rst_n && load) |=> q == $past(d));

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        (rst_n && !load) |=> $stable(q));
endmodule

// File: rtl/dual_byte_loader.sv
// Module dual_byte_loader
// Byte-wide loader for two 12-bit channels. Writes go to per-channel
// staging registers; a shared update moves both into the output registers
// together, and update together with a write passes the byte straight through.
// Assumes host strobes are synchronous to clk; clr_n may be asynchronous.
module dual_byte_loader (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr_n,
    input  logic        sel_n,
    input  logic        wr_n,
    input  logic        upd_n,
    input  logic [1:0]  addr,
    input  logic [7:0]  din,
    output logic [11:0] out_a,
    output logic [11:0] out_b
);
    import dbl_pkg::*;

    logic [CH_CNT-1:0] wr_lo;
    logic [CH_CNT-1:0] wr_hi;
    logic [WORD_W-1:0] stage_q   [CH_CNT];
    logic [WORD_W-1:0] stage_nxt [CH_CNT];
    logic [WORD_W-1:0] dac_q     [CH_CNT];
    logic              commit;

    // The shared commit needs update and the write strobe together.
    assign commit = ~upd_n & ~wr_n;

    dbl_addr_decode #(
        .CH_CNT (CH_CNT),
        .CH_AW  (CH_AW),
        .ADDR_W (ADDR_W)
    ) i_decode (
        .sel_n (sel_n),
        .wr_n  (wr_n),
        .addr  (addr),
        .wr_lo (wr_lo),
        .wr_hi (wr_hi)
    );

    for (genvar c = 0; c < CH_CNT; c++) begin : g_ch
        dbl_input_bank #(
            .BUS_W  (BUS_W),
            .NIB_W  (NIB_W),
            .WORD_W (WORD_W)
        ) i_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr_n     (clr_n),
            .wr_lo     (wr_lo[c]),
            .wr_hi     (wr_hi[c]),
            .din       (din),
            .word      (stage_q[c]),
            .word_next (stage_nxt[c])
        );

        dbl_commit_reg #(
            .WORD_W (WORD_W)
        ) i_commit (
            .clk   (clk),
            .rst_n (rst_n),
            .clr_n (clr_n),
            .load  (commit),
            .d     (stage_nxt[c]),
            .q     (dac_q[c])
        );
    end

    assign out_a = dac_q[0];
    assign out_b = dac_q[1];

    // R3
    no_update_chk: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        (rst_n && upd_n) |=> ($stable(out_a) && $stable(out_b)));

    // R5
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        (rst_n && !upd_n && !sel_n && !wr_n && addr == 2'd0) |=> out_a[7:0] == $past(din));

    // R7
    clear_chk: assert property (@(posedge clk)
        !clr_n |-> (out_a == '0 && out_b == '0));

    // R9
    reset_chk: assert property (@(posedge clk) disable iff (!clr_n)
        !rst_n |=> (out_a == '0 && out_b == '0));
endmodule

// File: tb/test_dual_byte_loader.sv
module test_dual_byte_loader;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr_n = 1'b1;
    logic        sel_n = 1'b1;
    logic        wr_n = 1'b1;
    logic        upd_n = 1'b1;
    logic [1:0]  addr = 2'd0;
    logic [7:0]  din = 8'd0;
    logic [11:0] out_a;
    logic [11:0] out_b;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    string cur_req = "R9";

    // Behavioural reference: staged bytes and committed words per channel.
    int m_lo [2];
    int m_hi [2];
    int m_out[2];

    always #4 clk = ~clk;

    dual_byte_loader i_dual_byte_loader (
        .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .sel_n(sel_n), .wr_n(wr_n),
        .upd_n(upd_n), .addr(addr), .din(din), .out_a(out_a), .out_b(out_b)
    );

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%03h expected=%03h", req, act, exp);
        end
    endtask

    task automatic model_zero();
        for (int c = 0; c < 2; c++) begin
            m_lo[c] = 0; m_hi[c] = 0; m_out[c] = 0;
        end
    endtask

    // Apply one cycle of inputs, advance the model past the edge, compare.
    task automatic cyc(bit s, bit w, bit u, int a, int d);
        sel_n = s; wr_n = w; upd_n = u; addr = 2'(a); din = 8'(d);
        @(posedge clk);
        #2;
        if (!rst_n) model_zero();
        else begin
            if (!s && !w) begin
                if (a[0]) m_hi[a[1]] = d & 'hF;
                else      m_lo[a[1]] = d & 'hFF;
            end
            if (!u && !w)
                for (int c = 0; c < 2; c++) m_out[c] = (m_hi[c] << 8) | m_lo[c];
        end
        check({cur_req, " out_a"}, int'(out_a), m_out[0]);
        check({cur_req, " out_b"}, int'(out_b), m_out[1]);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 8);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        model_zero();
        @(negedge clk);
        // R9: reset state
        cur_req = "R9";
        cyc(1, 1, 1, 0, 0);
        cyc(1, 1, 1, 0, 0);
        rst_n = 1'b1;
        check("R9 reset out_a", int'(out_a), 0);

        // R8: nibble mapping, upper bus bits ignored
        cur_req = "R8";
        cyc(0, 0, 1, 0, 'hBC);
        cyc(0, 0, 1, 1, 'hFA);
        cyc(1, 0, 0, 0, 'h00);
        check("R8 direct", int'(out_a), 'hABC);

        // R1/R2: channel B fill, A untouched
        cur_req = "R2";
        cyc(0, 0, 1, 2, 'h34);
        cyc(0, 0, 1, 3, 'h52);
        cyc(1, 0, 0, 3, 'hFF);
        check("R2 direct b", int'(out_b), 'h234);
        check("R1 direct a kept", int'(out_a), 'hABC);

        // R3: random writes with update idle; outputs must hold
        cur_req = "R3";
        for (int i = 0; i < 300; i++)
            cyc($urandom_range(0, 1), $urandom_range(0, 1), 1, $urandom_range(0, 3), $urandom_range(0, 255));
        // R4: commit what was staged
        cur_req = "R4";
        cyc(1, 0, 0, $urandom_range(0, 3), $urandom_range(0, 255));

        // R6: update with strobe idle, noisy bus
        cur_req = "R6";
        for (int i = 0; i < 40; i++)
            cyc($urandom_range(0, 1), 1, $urandom_range(0, 1), $urandom_range(0, 3), $urandom_range(0, 255));

        // R5: transparent writes
        cur_req = "R5";
        for (int i = 0; i < 40; i++)
            cyc(0, 0, 0, $urandom_range(0, 3), $urandom_range(0, 255));
        cyc(0, 0, 0, 0, 'h5A);
        check("R5 direct low", int'(out_a[7:0]), 'h5A);

        // R1: mixed random traffic
        cur_req = "R1";
        for (int i = 0; i < 2000; i++)
            cyc($urandom_range(0, 1), $urandom_range(0, 1), ($urandom_range(0, 3) != 0),
                $urandom_range(0, 3), $urandom_range(0, 255));

        // R7: async clear between edges
        cur_req = "R7";
        cyc(0, 0, 0, 1, 'h0F);
        #1 clr_n = 1'b0;
        #1;
        check("R7 async a", int'(out_a), 0);
        check("R7 async b", int'(out_b), 0);
        model_zero();
        @(posedge clk);
        #2;
        check("R7 held a", int'(out_a), 0);
        @(negedge clk);
        clr_n = 1'b1;
        cyc(1, 0, 0, 0, 0);
        check("R7 staged empty", int'(out_b), 0);

        // R9: sync reset after traffic
        cur_req = "R9";
        cyc(0, 0, 0, 2, 'hEE);
        rst_n = 1'b0;
        cyc(1, 1, 1, 0, 0);
        rst_n = 1'b1;
        cyc(1, 0, 0, 0, 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule